// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Page Buffer

This block is the bus-side controller of a 256-byte nonvolatile-style memory that sits on an I2C bus as a target. A fast system clock samples the serial clock and data lines. The block detects START and STOP, compares the 7-bit device address and decodes the direction bit. It pulls the data line low through an open-drain enable whenever it has to acknowledge or send a zero bit. The memory array is held in flops and cleared at reset, so every run starts from a known state.

A write transaction carries a one-byte word address and up to a page of data bytes. The data bytes collect in a 16-entry page buffer. They reach the array only when a STOP closes the transaction. The buffer then drains during a timed internal write cycle, and the block ignores the bus for that whole cycle. The block offers three kinds of read. A current-address read continues from the internal pointer. A random read sets the pointer with a write that carries no data, then uses a repeated START. A sequential read continues for as long as the master keeps acknowledging. Two inputs can veto the commit at STOP: a write-protect input and a supply-good input.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The block acknowledges an address byte only when bits 7..1 equal the parameter DEV_ADDR. Bit 0 is the direction (0 = write, 1 = read). An address byte that does not match gets no acknowledge, and the block ignores the bus until the next START.
- R2: The data line is only ever pulled low, through sda_oe_o = 1. sda_oe_o is 0 out of reset and whenever the bus is idle, and it changes only while SCL is low.
- R3: A write sends the address byte with bit 0 = 0, then a word address, then 1 to 16 data bytes, then STOP. Every byte is acknowledged. Data byte k lands at the word address with its low 4 bits advanced by k, modulo 16.
- R4: When more than 16 data bytes arrive, the low 4 bits wrap inside the same 16-byte page and later bytes overwrite earlier buffer entries. The upper 4 address bits never change during a write.
- R5: Nothing is written and no write cycle starts in these cases: a STOP arrives before the word address is complete, a STOP arrives with zero data bytes, or a repeated START arrives inside a write.
- R6: A STOP that commits starts a write cycle of WRITE_CYCLES clocks. During this cycle the block acknowledges nothing, including its own address. Afterwards it acknowledges again.
- R7: If wp_i is 1 when the STOP arrives, all bytes are still acknowledged, but the array is not changed and no write cycle starts.
- R8: If supply_ok_i is 0 when the STOP arrives, all bytes are still acknowledged, but the array is not changed and no write cycle starts.
- R9: A random read returns the byte at the word address that the preceding data-less write sent, with the first data bit driven most significant bit first.
- R10: A sequential read advances the full 8-bit address after each byte and wraps from 255 to 0. A master NACK ends the read.
- R11: A current-address read returns the byte at the internal pointer. The pointer is one past the last byte read. After a write, it is the word address with its low 4 bits advanced by the number of data bytes, modulo 16.
- R12: After reset every array byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| wp_i | input | 1 | Write protect; 1 vetoes the commit at STOP |
| supply_ok_i | input | 1 | Supply good; 0 vetoes the commit at STOP |

## Verification
The address decode is swept over all 128 seven-bit addresses, so only the matching one can draw an acknowledge. A single-byte write is placed at each of the 16 offsets of one page, and the whole page is read back after every write. This separates correct offset placement from stray writes to neighbouring bytes. Other transactions cover a page write that overruns by four bytes, a sequential read across the top of the address space, and polling during the write cycle. Further writes are vetoed by write protect, by low supply, and by being cut short with a STOP or repeated START. Each outcome is told apart by whether the very next address byte is acknowledged and by reading the affected bytes back.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_ADDR      = 4'd1,
        ST_ACK_ADDR  = 4'd2,
        ST_WADDR     = 4'd3,
        ST_ACK_WADDR = 4'd4,
        ST_WDATA     = 4'd5,
        ST_ACK_WDATA = 4'd6,
        ST_RDATA     = 4'd7,
        ST_RACK      = 4'd8,
        ST_BUSY      = 4'd9
    } eep_state_e;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_sh   = {s_q.scl_sh[STAGES-2:0], scl_i};
        s_d.sda_sh   = {s_q.sda_sh[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_sh[STAGES-1];
        s_d.sda_prev = s_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o      = s_q.scl_sh[STAGES-1];
    assign sda_o      = s_q.sda_sh[STAGES-1];
    assign scl_rise_o = scl_o & ~s_q.scl_prev;
    assign scl_fall_o = ~scl_o & s_q.scl_prev;
    assign start_o    = scl_o & s_q.scl_prev & s_q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & s_q.scl_prev & ~s_q.sda_prev & sda_o;

endmodule

// File: rtl/eep_regfile.sv
module eep_regfile #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[i];
            if (we && (waddr == IW'(i))) ent_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d;
        end
    end

    assign rdata = ent_q[raddr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int         MEM_BYTES    = 256,
    parameter int         PAGE_BYTES   = 16,
    parameter int         WRITE_CYCLES = 500000,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic wp_i,
    input  logic supply_ok_i
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        eep_state_e             st;
        logic [3:0]             bitcnt;
        logic [BYTE_W-1:0]      shreg;
        logic                   rw;
        logic                   mack;
        logic [AW-1:0]          ptr;
        logic [PAGE_BYTES-1:0]  mask;
        logic                   drive;
        logic [CW-1:0]          bcnt;
        logic [PW:0]            cidx;
    } ctl_t;

    ctl_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    // page buffer: written per data byte, drained during the write cycle
    logic              buf_we;
    logic [BYTE_W-1:0] buf_rdata;

    eep_regfile #(.DEPTH(PAGE_BYTES), .W(BYTE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .waddr (q.ptr[PW-1:0]),
        .wdata (q.shreg),
        .raddr (q.cidx[PW-1:0]),
        .rdata (buf_rdata)
    );

    // array: one write port used only while the write cycle drains the buffer
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [BYTE_W-1:0] mem_rdata;

    assign mem_we    = (q.st == ST_BUSY) && !q.cidx[PW] && q.mask[q.cidx[PW-1:0]];
    assign mem_waddr = {q.ptr[AW-1:PW], q.cidx[PW-1:0]};

    eep_regfile #(.DEPTH(MEM_BYTES), .W(BYTE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (buf_rdata),
        .raddr (q.ptr),
        .rdata (mem_rdata)
    );

    logic commit_ok;
    assign commit_ok = !wp_i && supply_ok_i;

    always_comb begin
        n      = q;
        buf_we = 1'b0;

        if (q.st == ST_BUSY) begin
            n.bcnt = q.bcnt + CW'(1);
            if (!q.cidx[PW]) n.cidx = q.cidx + (PW+1)'(1);
            if (q.bcnt == CW'(WRITE_CYCLES - 1)) begin
                n.st   = ST_IDLE;
                n.mask = '0;
            end
        end else if (start_det) begin
            n.st     = ST_ADDR;
            n.bitcnt = '0;
            n.drive  = 1'b0;
            n.mask   = '0;
        end else if (stop_det) begin
            n.drive = 1'b0;
            if ((q.mask != '0) && commit_ok) begin
                n.st   = ST_BUSY;
                n.bcnt = '0;
                n.cidx = '0;
            end else begin
                n.st   = ST_IDLE;
                n.mask = '0;
            end
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && (q.bitcnt < 4'd8)) begin
                        n.shreg  = {q.shreg[BYTE_W-2:0], sda_s};
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && (q.bitcnt == 4'd8)) begin
                        n.bitcnt = '0;
                        n.drive  = 1'b1;
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                n.rw = q.shreg[0];
                                n.st = ST_ACK_ADDR;
                            end else begin
                                n.drive = 1'b0;
                                n.st    = ST_IDLE;
                            end
                        end else if (q.st == ST_WADDR) begin
                            n.ptr = q.shreg;
                            n.st  = ST_ACK_WADDR;
                        end else begin
                            buf_we               = 1'b1;
                            n.mask[q.ptr[PW-1:0]] = 1'b1;
                            n.ptr = {q.ptr[AW-1:PW], q.ptr[PW-1:0] + PW'(1)};
                            n.st  = ST_ACK_WDATA;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        n.bitcnt = '0;
                        if (q.rw) begin
                            n.shreg = mem_rdata;
                            n.ptr   = q.ptr + AW'(1);
                            n.drive = ~mem_rdata[BYTE_W-1];
                            n.st    = ST_RDATA;
                        end else begin
                            n.drive = 1'b0;
                            n.st    = ST_WADDR;
                        end
                    end
                end
                ST_ACK_WADDR, ST_ACK_WDATA: begin
                    if (scl_fall) begin
                        n.drive  = 1'b0;
                        n.bitcnt = '0;
                        n.st     = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            n.drive = 1'b0;
                            n.st    = ST_RACK;
                        end else begin
                            n.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            n.drive = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_s;
                    end else if (scl_fall) begin
                        n.bitcnt = '0;
                        if (q.mack) begin
                            n.shreg = mem_rdata;
                            n.ptr   = q.ptr + AW'(1);
                            n.drive = ~mem_rdata[BYTE_W-1];
                            n.st    = ST_RDATA;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o = q.drive;

    // observation points for the bound checker
    eep_state_e    cur_st;
    logic [AW-1:0] cur_ptr;
    logic [CW-1:0] cur_bcnt;
    assign cur_st   = q.st;
    assign cur_ptr  = q.ptr;
    assign cur_bcnt = q.bcnt;

endmodule

// File: rtl/eep_checker.sv
module eep_checker
    import eep_pkg::*;
#(
    parameter int WRITE_CYCLES = 500000,
    localparam int CW = $clog2(WRITE_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe_o,
    input logic          scl_s,
    input logic          wp_i,
    input logic          supply_ok_i,
    input eep_state_e    st,
    input logic [7:0]    ptr,
    input logic [CW-1:0] bcnt
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_oe_in_drive_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (st inside {ST_ACK_ADDR, ST_ACK_WADDR, ST_ACK_WDATA, ST_RDATA}));

    assert_oe_stable_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

    assert_busy_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |-> !sda_oe_o);

    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |-> (bcnt < CW'(WRITE_CYCLES)));

    assert_commit_permitted_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && st == ST_BUSY && $past(st) != ST_BUSY)
            |-> ($past(wp_i) == 1'b0 && $past(supply_ok_i) == 1'b1));

    assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (st inside {ST_WDATA, ST_ACK_WDATA})
                 && ($past(st) inside {ST_WDATA, ST_ACK_WDATA}))
            |-> (ptr[7:4] == $past(ptr[7:4])));

endmodule

bind i2c_eeprom_target eep_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_oe_o    (sda_oe_o),
    .scl_s       (scl_s),
    .wp_i        (wp_i),
    .supply_ok_i (supply_ok_i),
    .st          (cur_st),
    .ptr         (cur_ptr),
    .bcnt        (cur_bcnt)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;

    localparam logic [6:0] DEV = 7'h50;
    localparam int WC = 600;
    localparam int Q  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, m_scl_low, m_sda_low, wp, sok;
    logic sda_oe, scl_line, sda_line;
    assign scl_line = ~m_scl_low;
    assign sda_line = ~(m_sda_low | sda_oe);

    i2c_eeprom_target #(.DEV_ADDR(DEV), .WRITE_CYCLES(WC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .wp_i        (wp),
        .supply_ok_i (sok)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [256];
    logic [7:0] mptr;

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 1) & 255);
    endfunction

    task automatic bus_start();
        m_sda_low = 1'b0; tick(Q);
        m_scl_low = 1'b0; tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic bus_stop();
        tick(2);
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b0; tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(2);
            m_sda_low = ~b[i]; tick(Q);
            m_scl_low = 1'b0;  tick(Q);
            m_scl_low = 1'b1;
        end
        tick(2);
        m_sda_low = 1'b0; tick(Q);
        m_scl_low = 1'b0; tick(Q / 2);
        ack = (sda_line == 1'b0);
        tick(Q / 2);
        m_scl_low = 1'b1;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl_low = 1'b0; tick(Q / 2);
            b[i] = sda_line;
            tick(Q / 2);
            m_scl_low = 1'b1;
        end
        tick(2);
        m_sda_low = give_ack; tick(Q);
        m_scl_low = 1'b0;     tick(Q);
        m_scl_low = 1'b1;     tick(2);
        m_sda_low = 1'b0;
    endtask

    // write transaction; model follows the commit rules
    task automatic write_txn(input logic [7:0] wa, input int nb, input int seed, input string req);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack); check(req, ack, 1, "write address ack");
        send_byte(wa, ack);          check(req, ack, 1, "word address ack");
        for (int i = 0; i < nb; i++) begin
            send_byte(pat(seed, i), ack);
            check(req, ack, 1, "data byte ack");
        end
        bus_stop();
        if (nb > 0 && !wp && sok)
            for (int i = 0; i < nb; i++)
                model[{wa[7:4], wa[3:0] + 4'(i)}] = pat(seed, i);
        mptr = {wa[7:4], wa[3:0] + 4'(nb)};
    endtask

    task automatic poll(input logic exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        bus_stop();
        check(req, ack, exp_ack, "poll address ack");
    endtask

    task automatic rand_read(input logic [7:0] wa, input int nb, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, ack); check(req, ack, 1, "dummy write ack");
        send_byte(wa, ack);          check(req, ack, 1, "read word address ack");
        bus_start();
        send_byte({DEV, 1'b1}, ack); check(req, ack, 1, "read address ack");
        for (int i = 0; i < nb; i++) begin
            recv_byte(i != nb - 1, b);
            check(req, b, model[8'(wa + 8'(i))], $sformatf("read byte at %0h", 8'(wa + 8'(i))));
        end
        bus_stop();
        mptr = 8'(wa + 8'(nb));
    endtask

    task automatic cur_read(input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b1}, ack); check(req, ack, 1, "current read address ack");
        recv_byte(1'b0, b);
        bus_stop();
        check(req, b, model[mptr], "current address byte");
        mptr = mptr + 8'd1;
    endtask

    initial begin
        rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0; wp = 1'b0; sok = 1'b1;
        mptr = '0;
        for (int i = 0; i < 256; i++) model[i] = '0;
        tick(5);
        check("R2", sda_oe, 0, "oe during reset");
        rst_n = 1'b1;
        tick(5);
        check("R2", sda_oe, 0, "oe idle after reset");

        // R12: cleared array
        rand_read(8'h10, 4, "R12");

        // R1: sweep all device addresses (also R5: stop after address only)
        for (int a = 0; a < 128; a++) begin
            logic ack;
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            bus_stop();
            check("R1", ack, (7'(a) == DEV), $sformatf("ack for address %0h", a));
        end
        poll(1'b1, "R5");

        // R3 / R6: full page write, busy polling, readback
        write_txn(8'h30, 16, 3, "R3");
        poll(1'b0, "R6");
        tick(WC);
        poll(1'b1, "R6");
        cur_read("R11");
        rand_read(8'h30, 16, "R3");

        // R3 offset sweep: single-byte writes over one page
        for (int off = 0; off < 16; off++) begin
            write_txn({4'hA, 4'(off)}, 1, off + 7, "R3");
            tick(WC + 20);
            rand_read(8'hA0, 16, "R3");
        end

        // R4: overrun by four bytes wraps in page
        write_txn(8'h5C, 20, 9, "R4");
        tick(WC + 20);
        cur_read("R11");
        rand_read(8'h4F, 18, "R4");

        // R10: sequential read over the top of the address space
        write_txn(8'hFE, 2, 21, "R3");
        tick(WC + 20);
        write_txn(8'h00, 2, 22, "R3");
        tick(WC + 20);
        rand_read(8'hFD, 5, "R10");
        cur_read("R11");

        // R9: random read of a single byte
        rand_read(8'h35, 1, "R9");
        cur_read("R11");

        // R7: write protect
        wp = 1'b1;
        write_txn(8'h60, 4, 30, "R7");
        poll(1'b1, "R7");
        wp = 1'b0;
        rand_read(8'h60, 4, "R7");

        // R8: low supply
        sok = 1'b0;
        write_txn(8'h31, 3, 31, "R8");
        poll(1'b1, "R8");
        sok = 1'b1;
        rand_read(8'h30, 4, "R8");

        // R5: word address then STOP sets the pointer only
        write_txn(8'h3A, 0, 0, "R5");
        poll(1'b1, "R5");
        write_txn(8'h3A, 0, 0, "R5");
        cur_read("R11");

        // R5: repeated START inside a write with data
        begin
            logic ack;
            bus_start();
            send_byte({DEV, 1'b0}, ack); check("R5", ack, 1, "address ack");
            send_byte(8'h70, ack);       check("R5", ack, 1, "word address ack");
            send_byte(8'hA5, ack);       check("R5", ack, 1, "data ack");
            send_byte(8'h5A, ack);       check("R5", ack, 1, "data ack");
            bus_start();
            send_byte({DEV, 1'b0}, ack); check("R5", ack, 1, "restart address ack");
            bus_stop();
        end
        poll(1'b1, "R5");
        rand_read(8'h70, 2, "R5");

        check("R2", sda_oe, 0, "oe idle at end");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule